// File: doc/BRIEF.md
# Paged MDIO to 32-bit Register Bridge

This block sits on a Clause 22 management bus as a slave and gives a host that can only issue 16-bit management frames access to a wide space of 32-bit internal registers. The upper part of each internal address comes from a page value that the host sets by writing to one dedicated PHY address. The lower part comes from the PHY address and the register number of each data frame. A band of eight PHY addresses carries data. An even register number in a frame moves bits 15:0 of a word, and the next odd register number moves bits 31:16.

The host writes a word as two frames: the upper half first, then the lower half. The bridge keeps the upper half and issues a single 32-bit internal write when the lower half arrives. The host reads a word by fetching the lower half first. That frame starts one internal read and keeps bits 31:16 of the result, so the next odd-register frame returns them without touching the internal bus again. The management clock is sampled in the system clock domain. One management clock period has to span at least eight system clocks, and internal read data is taken in the cycle after the read strobe.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset no strobe is active, the MDIO output enable is low, and the page, the held upper write half and the latched upper read half are all zero.
- R2: A write frame to PHY address 0x18, register 0, stores data bits 8:0 as the page and causes no internal access. A read frame to the same place returns the page, zero-extended to 16 bits.
- R3: An internal access uses the byte address {page[8:0], phy[2:0], reg[4:1], 2'b00}, which is 18 bits wide.
- R4: A write frame to PHY 0x10 to 0x17 with an odd register number only stores its 16 data bits as the held upper half. It issues no internal write.
- R5: A write frame to PHY 0x10 to 0x17 with an even register number issues exactly one internal write strobe. The write data is {held upper half, frame data}. The held upper half is kept for later frames.
- R6: A read frame to PHY 0x10 to 0x17 with an even register number issues exactly one internal read strobe. It returns bits 15:0 of the read word and latches bits 31:16.
- R7: A read frame to PHY 0x10 to 0x17 with an odd register number returns the latched upper half and issues no internal read.
- R8: A frame to any PHY address outside 0x10 to 0x18, or to 0x18 with a nonzero register number, causes no strobe, leaves the page unchanged and never drives MDIO.
- R9: A frame is accepted only after at least 32 consecutive 1 bits of preamble followed by the start pattern 01. Opcode 10 means read and 01 means write, with PHY and register addresses sent MSB first.
- R10: On an accepted read the bridge drives 0 in the second turnaround bit and then 16 data bits MSB first. It releases MDIO after the last data bit and never drives it during a write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mdc | input | 1 | Management clock from the host |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdio_o | output | 1 | Value driven onto the management data line |
| mdio_oe | output | 1 | Drive enable for the management data line |
| bus_addr | output | 18 | Internal byte address of the current access |
| bus_wdata | output | 32 | Internal write data |
| bus_wr | output | 1 | One-cycle internal write strobe |
| bus_rd | output | 1 | One-cycle internal read strobe |
| bus_rdata | input | 32 | Internal read data, valid the cycle after bus_rd |

## Verification
A corrupted page or held upper half does not show when it is loaded. It shows only at the next internal strobe, as a wrong address or a wrong bits 31:16, so every page change and every upper-half write is followed by a lower-half access that exposes it. A bad upper-half latch shows only on the next odd-register read frame, about one frame (roughly 500 system clocks) later. A receiver that has lost bit alignment makes the next frame's strobes or turnaround bit wrong. For that reason each frame checks strobe counts, the sampled turnaround bit and the MDIO enable state, not only the returned data.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

    localparam int PAGE_W   = 9;
    localparam int R2_W     = 3;
    localparam int REGSEL_W = 4;
    localparam int BYTE_W   = 2;
    localparam int ADDR_W   = PAGE_W + R2_W + REGSEL_W + BYTE_W;
    localparam int HALF_W   = 16;
    localparam int WORD_W   = 2 * HALF_W;
    localparam int PHY_W    = 5;
    localparam int REG_W    = 5;
    localparam int HDR_W    = 2 + PHY_W + REG_W;

    localparam logic [PHY_W-1:0] DATA_PHY_BASE = 5'h10;
    localparam logic [PHY_W-1:0] PAGE_PHY      = 5'h18;
    localparam logic [REG_W-1:0] PAGE_REG      = 5'd0;

    typedef enum logic [1:0] {
        OP_RSVD0 = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_RSVD3 = 2'b11
    } mgmt_op_e;

    typedef struct packed {
        mgmt_op_e         op;
        logic [PHY_W-1:0] phy;
        logic [REG_W-1:0] regno;
    } mgmt_hdr_t;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_PAGE,
        TGT_LOW,
        TGT_HIGH
    } target_e;

    typedef enum logic [2:0] {
        RX_PRE,
        RX_START,
        RX_HDR,
        RX_TURN,
        RX_DATA
    } rx_state_e;

    function automatic target_e classify(mgmt_hdr_t h);
        if (h.phy[PHY_W-1:R2_W] == DATA_PHY_BASE[PHY_W-1:R2_W])
            return h.regno[0] ? TGT_HIGH : TGT_LOW;
        else if (h.phy == PAGE_PHY && h.regno == PAGE_REG)
            return TGT_PAGE;
        else
            return TGT_NONE;
    endfunction

    function automatic logic [ADDR_W-1:0] word_addr(logic [PAGE_W-1:0] page, mgmt_hdr_t h);
        return {page, h.phy[R2_W-1:0], h.regno[REG_W-1:1], {BYTE_W{1'b0}}};
    endfunction

endpackage

// File: rtl/mdc_edge_sync.sv
module mdc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mdc,
    input  logic mdio_i,
    output logic mdc_rise,
    output logic mdio_s
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic             mdc_prev;

    assign raw = {mdc, mdio_i};

    generate
        for (genvar g = 0; g < LINES; g++) begin : gen_line
            logic [STAGES-1:0] sr;
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= {sr[STAGES-2:0], raw[g]};
            end
            assign synced[g] = sr[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) mdc_prev <= 1'b0;
        else     mdc_prev <= synced[1];
    end

    assign mdc_rise = synced[1] & ~mdc_prev;
    assign mdio_s   = synced[0];

endmodule

// File: rtl/mgmt_frame_rx.sv
module mgmt_frame_rx
    import mdio_bridge_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              bit_in,
    input  logic              resp_valid,
    input  logic [HALF_W-1:0] resp_data,
    output logic              hdr_evt,
    output mgmt_hdr_t         hdr,
    output logic              wr_evt,
    output logic [HALF_W-1:0] wr_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int PC_W  = $clog2(PRE_LEN + 1);
    localparam int POS_W = 4;

    rx_state_e         state;
    logic [PC_W-1:0]   pre_cnt;
    logic [POS_W-1:0]  pos;
    logic [HALF_W-1:0] shreg;
    logic [HALF_W-1:0] tx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_PRE;
            pre_cnt <= '0;
            pos     <= '0;
            shreg   <= '0;
            tx      <= '0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
            hdr_evt <= 1'b0;
            hdr     <= '0;
            wr_evt  <= 1'b0;
            wr_data <= '0;
        end else begin
            hdr_evt <= 1'b0;
            wr_evt  <= 1'b0;
            if (rise) begin
                case (state)
                    RX_PRE: begin
                        if (bit_in) begin
                            if (pre_cnt != PC_W'(PRE_LEN)) pre_cnt <= pre_cnt + 1'b1;
                        end else if (pre_cnt == PC_W'(PRE_LEN)) begin
                            state   <= RX_START;
                            pre_cnt <= '0;
                        end else begin
                            pre_cnt <= '0;
                        end
                    end
                    RX_START: begin
                        pos   <= '0;
                        state <= bit_in ? RX_HDR : RX_PRE;
                    end
                    RX_HDR: begin
                        shreg <= {shreg[HALF_W-2:0], bit_in};
                        pos   <= pos + 1'b1;
                        if (pos == POS_W'(HDR_W - 1)) begin
                            hdr     <= mgmt_hdr_t'({shreg[HDR_W-2:0], bit_in});
                            hdr_evt <= 1'b1;
                            state   <= RX_TURN;
                            pos     <= '0;
                        end
                    end
                    RX_TURN: begin
                        if (pos == '0) begin
                            pos <= pos + 1'b1;
                            if (resp_valid && hdr.op == OP_READ) begin
                                mdio_oe <= 1'b1;
                                mdio_o  <= 1'b0;
                                tx      <= resp_data;
                            end
                        end else begin
                            pos   <= '0;
                            state <= RX_DATA;
                            if (mdio_oe) begin
                                mdio_o <= tx[HALF_W-1];
                                tx     <= {tx[HALF_W-2:0], 1'b0};
                            end
                        end
                    end
                    RX_DATA: begin
                        shreg <= {shreg[HALF_W-2:0], bit_in};
                        pos   <= pos + 1'b1;
                        if (pos == POS_W'(HALF_W - 1)) begin
                            mdio_oe <= 1'b0;
                            mdio_o  <= 1'b0;
                            state   <= RX_PRE;
                            pre_cnt <= '0;
                            pos     <= '0;
                            if (hdr.op == OP_WRITE) begin
                                wr_evt  <= 1'b1;
                                wr_data <= {shreg[HALF_W-2:0], bit_in};
                            end
                        end else if (mdio_oe) begin
                            mdio_o <= tx[HALF_W-1];
                            tx     <= {tx[HALF_W-2:0], 1'b0};
                        end
                    end
                    default: state <= RX_PRE;
                endcase
            end
        end
    end

    // R10: the line is driven only inside the turnaround/data part of a frame
    assert_oe_window_R10: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> (state == RX_TURN || state == RX_DATA));

    // R10: a write frame never drives the line
    assert_no_drive_on_write_R10: assert property (@(posedge clk) disable iff (rst)
        (mdio_oe && state == RX_DATA) |-> hdr.op == OP_READ);

    // R5: one write event per frame
    assert_wr_evt_single_R5: assert property (@(posedge clk) disable iff (rst)
        wr_evt |=> !wr_evt);

endmodule

// File: rtl/page_access_seq.sv
module page_access_seq
    import mdio_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_evt,
    input  mgmt_hdr_t         hdr,
    input  logic              wr_evt,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic              resp_valid,
    output logic [HALF_W-1:0] resp_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd
);
    mgmt_hdr_t         cur_hdr;
    logic [PAGE_W-1:0] page_q;
    logic [HALF_W-1:0] wr_hold;
    logic [HALF_W-1:0] rd_hold;
    logic              rd_cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_hdr    <= '0;
            page_q     <= '0;
            wr_hold    <= '0;
            rd_hold    <= '0;
            rd_cap     <= 1'b0;
            resp_valid <= 1'b0;
            resp_data  <= '0;
            bus_addr   <= '0;
            bus_wdata  <= '0;
            bus_wr     <= 1'b0;
            bus_rd     <= 1'b0;
        end else begin
            bus_wr <= 1'b0;
            bus_rd <= 1'b0;
            rd_cap <= bus_rd;

            if (hdr_evt) begin
                cur_hdr    <= hdr;
                resp_valid <= 1'b0;
                if (hdr.op == OP_READ) begin
                    case (classify(hdr))
                        TGT_LOW: begin
                            bus_rd   <= 1'b1;
                            bus_addr <= word_addr(page_q, hdr);
                        end
                        TGT_HIGH: begin
                            resp_data  <= rd_hold;
                            resp_valid <= 1'b1;
                        end
                        TGT_PAGE: begin
                            resp_data  <= HALF_W'(page_q);
                            resp_valid <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end

            if (rd_cap) begin
                rd_hold    <= bus_rdata[WORD_W-1:HALF_W];
                resp_data  <= bus_rdata[HALF_W-1:0];
                resp_valid <= 1'b1;
            end

            if (wr_evt) begin
                case (classify(cur_hdr))
                    TGT_PAGE: page_q  <= wr_data[PAGE_W-1:0];
                    TGT_HIGH: wr_hold <= wr_data;
                    TGT_LOW: begin
                        bus_wr    <= 1'b1;
                        bus_wdata <= {wr_hold, wr_data};
                        bus_addr  <= word_addr(page_q, cur_hdr);
                    end
                    default: ;
                endcase
            end
        end
    end

    // R5/R6: reads and writes never overlap
    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_rd));

    // R6: an internal read follows a decoded header
    assert_rd_after_hdr_R6: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> $past(hdr_evt));

    // R5: an internal write follows a completed write frame
    assert_wr_after_frame_R5: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> $past(wr_evt));

    // R2: the page moves only on a completed write frame
    assert_page_change_R2: assert property (@(posedge clk) disable iff (rst)
        (page_q != $past(page_q)) |-> $past(wr_evt));

endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
    import mdio_bridge_pkg::*;
#(
    parameter int PRE_LEN     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [WORD_W-1:0] bus_rdata
);
    logic              rise;
    logic              bit_s;
    logic              hdr_evt;
    mgmt_hdr_t         hdr;
    logic              wr_evt;
    logic [HALF_W-1:0] wr_data;
    logic              resp_valid;
    logic [HALF_W-1:0] resp_data;

    mdc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .mdc      (mdc),
        .mdio_i   (mdio_i),
        .mdc_rise (rise),
        .mdio_s   (bit_s)
    );

    mgmt_frame_rx #(.PRE_LEN(PRE_LEN)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .rise       (rise),
        .bit_in     (bit_s),
        .resp_valid (resp_valid),
        .resp_data  (resp_data),
        .hdr_evt    (hdr_evt),
        .hdr        (hdr),
        .wr_evt     (wr_evt),
        .wr_data    (wr_data),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );

    page_access_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .hdr_evt    (hdr_evt),
        .hdr        (hdr),
        .wr_evt     (wr_evt),
        .wr_data    (wr_data),
        .bus_rdata  (bus_rdata),
        .resp_valid (resp_valid),
        .resp_data  (resp_data),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd)
    );

endmodule

// File: tb/sim_mdio_page_bridge.sv
module sim_mdio_page_bridge;

    localparam int HALF = 4;
    localparam int PRE  = 32;
    localparam int NV   = 21;

    // {read, phy[4:0], reg[4:0], data[15:0]}
    localparam logic [26:0] VEC [NV] = '{
        {1'b0, 5'h18, 5'd0,  16'h0123},
        {1'b1, 5'h18, 5'd0,  16'h0000},
        {1'b0, 5'h13, 5'd7,  16'hDEAD},
        {1'b0, 5'h13, 5'd6,  16'hBEEF},
        {1'b1, 5'h13, 5'd6,  16'h0000},
        {1'b1, 5'h13, 5'd7,  16'h0000},
        {1'b0, 5'h18, 5'd0,  16'hFFFF},
        {1'b0, 5'h17, 5'd31, 16'h1234},
        {1'b0, 5'h17, 5'd30, 16'h5678},
        {1'b1, 5'h10, 5'd0,  16'h0000},
        {1'b1, 5'h10, 5'd1,  16'h0000},
        {1'b0, 5'h05, 5'd0,  16'h4321},
        {1'b1, 5'h1F, 5'd2,  16'h0000},
        {1'b0, 5'h18, 5'd1,  16'h0055},
        {1'b1, 5'h18, 5'd0,  16'h0000},
        {1'b0, 5'h11, 5'd2,  16'hAAAA},
        {1'b1, 5'h11, 5'd2,  16'h0000},
        {1'b1, 5'h11, 5'd3,  16'h0000},
        {1'b0, 5'h19, 5'd4,  16'h7777},
        {1'b1, 5'h17, 5'd30, 16'h0000},
        {1'b1, 5'h17, 5'd31, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        mdc;
    logic        m_val;
    logic        m_en;
    logic        mdio_o, mdio_oe;
    logic [17:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_wr, bus_rd;
    logic [31:0] bus_rdata;
    wire         line = mdio_oe ? mdio_o : (m_en ? m_val : 1'b1);

    always #2 clk = ~clk;

    mdio_page_bridge u0 (
        .clk(clk), .rst(rst), .mdc(mdc), .mdio_i(line),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    // register space behind the bus
    logic [31:0] dev_mem [int];
    int          wr_cnt = 0, rd_cnt = 0, oe_cnt = 0;
    logic [17:0] last_wr_addr, last_rd_addr;
    logic [31:0] last_wr_data;

    function automatic logic [31:0] fill(logic [17:0] a);
        return {a[15:0] ^ 16'hC3A5, a[17:2]};
    endfunction

    always @(posedge clk) begin
        if (mdio_oe) oe_cnt++;
        if (bus_wr) begin
            dev_mem[int'(bus_addr)] = bus_wdata;
            wr_cnt++;
            last_wr_addr = bus_addr;
            last_wr_data = bus_wdata;
        end
        if (bus_rd) begin
            rd_cnt++;
            last_rd_addr = bus_addr;
            bus_rdata <= dev_mem.exists(int'(bus_addr)) ? dev_mem[int'(bus_addr)] : fill(bus_addr);
        end
    end

    // checking
    int  n_checks = 0, n_fail = 0;
    bit  finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bench reference state
    logic [8:0]  m_page = '0;
    logic [15:0] m_whold = '0;
    logic [15:0] m_rhold = '0;
    logic [31:0] m_mem [int];

    function automatic logic [17:0] ref_addr(logic [8:0] pg, logic [4:0] phy, logic [4:0] rg);
        return 18'(pg) * 18'd512 + 18'(phy % 8) * 18'd64 + 18'(rg / 2) * 18'd4;
    endfunction

    function automatic logic [31:0] ref_read(logic [17:0] a);
        return m_mem.exists(int'(a)) ? m_mem[int'(a)] : fill(a);
    endfunction

    task automatic mbit(input logic v, output logic s);
        @(negedge clk);
        m_val = v;
        mdc   = 1'b0;
        repeat (HALF - 1) @(negedge clk);
        s   = line;
        mdc = 1'b1;
        repeat (HALF) @(negedge clk);
        mdc = 1'b0;
    endtask

    task automatic frame(input int pre_n, input logic rd, input logic [4:0] phy,
                         input logic [4:0] rg, input logic [15:0] wd,
                         output logic [15:0] rdv, output logic ta2);
        logic s;
        m_en = 1'b1;
        rdv  = '0;
        ta2  = 1'b1;
        for (int i = 0; i < pre_n; i++) mbit(1'b1, s);
        mbit(1'b0, s);
        mbit(1'b1, s);
        mbit(rd, s);
        mbit(!rd, s);
        for (int i = 4; i >= 0; i--) mbit(phy[i], s);
        for (int i = 4; i >= 0; i--) mbit(rg[i], s);
        if (rd) begin
            m_en = 1'b0;
            mbit(1'b1, s);
            mbit(1'b1, ta2);
            for (int i = 15; i >= 0; i--) begin
                mbit(1'b1, s);
                rdv[i] = s;
            end
        end else begin
            mbit(1'b1, s);
            mbit(1'b0, s);
            for (int i = 15; i >= 0; i--) mbit(wd[i], s);
        end
        m_en = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        m_page  = '0;
        m_whold = '0;
        m_rhold = '0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rdv;
        logic        ta2;
        mdc = 1'b0; m_val = 1'b1; m_en = 1'b1; bus_rdata = '0;
        do_reset();

        // R1: reset state at the ports
        chk("R1 bus_wr", 32'(bus_wr), 0);
        chk("R1 bus_rd", 32'(bus_rd), 0);
        chk("R1 mdio_oe", 32'(mdio_oe), 0);

        for (int i = 0; i < NV; i++) begin
            logic        rd;
            logic [4:0]  phy, rg;
            logic [15:0] d;
            int          w0, r0, o0;
            bit          dat, pg;
            logic [17:0] a;
            logic [31:0] val;
            {rd, phy, rg, d} = VEC[i];
            w0 = wr_cnt; r0 = rd_cnt; o0 = oe_cnt;
            frame(PRE, rd, phy, rg, d, rdv, ta2);
            dat = (phy >= 5'h10 && phy <= 5'h17);
            pg  = (phy == 5'h18 && rg == 5'd0);
            a   = ref_addr(m_page, phy, rg);
            if (!rd) begin
                chk("R10 no drive on write", 32'(oe_cnt - o0), 0);
                if (pg) begin
                    m_page = d[8:0];
                    chk("R2 page write no access", 32'(wr_cnt - w0 + rd_cnt - r0), 0);
                end else if (dat && rg[0]) begin
                    m_whold = d;
                    chk("R4 upper half held", 32'(wr_cnt - w0), 0);
                end else if (dat) begin
                    m_mem[int'(a)] = {m_whold, d};
                    chk("R5 one write strobe", 32'(wr_cnt - w0), 1);
                    chk("R3 write address", 32'(last_wr_addr), 32'(a));
                    chk("R5 write data", last_wr_data, {m_whold, d});
                end else begin
                    chk("R8 ignored write", 32'(wr_cnt - w0 + rd_cnt - r0), 0);
                end
            end else begin
                if (pg) begin
                    chk("R2 page read", 32'(rdv), 32'(m_page));
                    chk("R10 turnaround", 32'(ta2), 0);
                end else if (dat && rg[0]) begin
                    chk("R7 upper from latch", 32'(rdv), 32'(m_rhold));
                    chk("R7 no read strobe", 32'(rd_cnt - r0), 0);
                    chk("R10 turnaround", 32'(ta2), 0);
                end else if (dat) begin
                    val = ref_read(a);
                    m_rhold = val[31:16];
                    chk("R6 lower half", 32'(rdv), 32'(val[15:0]));
                    chk("R6 one read strobe", 32'(rd_cnt - r0), 1);
                    chk("R3 read address", 32'(last_rd_addr), 32'(a));
                    chk("R10 turnaround", 32'(ta2), 0);
                end else begin
                    chk("R8 ignored read no drive", 32'(oe_cnt - o0), 0);
                    chk("R8 ignored read no strobe", 32'(wr_cnt - w0 + rd_cnt - r0), 0);
                end
                chk("R10 released after read", 32'(mdio_oe), 0);
            end
        end

        // R9: short preamble is rejected, full preamble accepted
        begin
            int w0;
            w0 = wr_cnt;
            frame(8, 1'b0, 5'h12, 5'd4, 16'h9999, rdv, ta2);
            chk("R9 short preamble ignored", 32'(wr_cnt - w0), 0);
            frame(PRE, 1'b0, 5'h12, 5'd4, 16'h9999, rdv, ta2);
            chk("R9 full preamble accepted", 32'(wr_cnt - w0), 1);
            chk("R9 data", last_wr_data, {m_whold, 16'h9999});
        end

        // R1: reset clears page and both held halves
        do_reset();
        chk("R1 oe after reset", 32'(mdio_oe), 0);
        frame(PRE, 1'b1, 5'h18, 5'd0, 16'h0, rdv, ta2);
        chk("R1 page cleared", 32'(rdv), 0);
        frame(PRE, 1'b1, 5'h16, 5'd5, 16'h0, rdv, ta2);
        chk("R1 read latch cleared", 32'(rdv), 0);
        frame(PRE, 1'b0, 5'h16, 5'd4, 16'h4242, rdv, ta2);
        chk("R1 write hold cleared", last_wr_data, 32'h0000_4242);
        chk("R1 address with page 0", 32'(last_wr_addr), 32'(ref_addr(9'd0, 5'h16, 5'd4)));

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule